// File: doc/BRIEF.md
# Repeating Horizontal Blanking Gate Generator

This block drives the horizontal blanking gate of an image sensor timing generator. It counts pixel clocks from a line-start strobe. Inside a programmed window, given by a start position and an end position, it raises the blanking level.

In repeat mode the first part of that window is not a flat level. A short pattern of programmable length is played a programmed number of times back to back, starting at the window start. Each copy of the pattern begins active, and up to six toggle positions invert the level inside the copy. Two toggle sets are provided. The line parity, sampled at the line-start strobe, picks which set is used for that line. Once the copies are used up, the gate stays active until the window end.

In any other mode the block produces a plain window, and the pattern settings are ignored.

Top module: `hblk_repeat_gen`

## Requirements
- R1: After reset, and until the first `line_start` strobe, `hblk` is 0 whatever the configuration is.
- R2: A clock edge that samples `line_start`=1 sets the pixel position to 0. The position then rises by one each clock. The value of `hblk` for position n is visible n+1 clock cycles after the sampling edge.
- R3: For a position below `win_start` or at or above `win_end`, `hblk` is 0 in every mode.
- R4: When `mode` is not 1, `hblk` is 1 at every position in [`win_start`, `win_end`). Pattern length, repeat count and toggle values have no effect.
- R5: When `mode` = 1 (value 2'b01), a pattern of `pat_len` positions starts at `win_start` and is emitted `rep_cnt` times in succession. Each copy begins with `hblk` = 1.
- R6: Toggle i sits in bits [i*PIX_W +: PIX_W] of a toggle bus. It holds an offset t relative to the start of each copy. When t < `pat_len`, it inverts `hblk` from offset t to the end of that copy. When t >= `pat_len`, it is ignored. An offset of 0 inverts the level from the first position of the copy.
- R7: `line_odd` is sampled on the edge that samples `line_start` and is held for the whole line. A sampled 1 selects `tog_odd`, and 0 selects `tog_even`. Later changes to `line_odd` have no effect until the next strobe.
- R8: In mode 1, positions inside the window that come after the last copy give `hblk` = 1. When `rep_cnt` = 0 or `pat_len` = 0, the whole window is 1.
- R9: Two toggles at the same valid offset each invert the level, so they cancel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_start | input | 1 | Line-start strobe, one cycle |
| line_odd | input | 1 | Line parity, 1 = odd line |
| mode | input | 2 | Blanking mode, 1 = repeating pattern |
| win_start | input | PIX_W (12) | First blanked pixel position |
| win_end | input | PIX_W (12) | First position past the window |
| pat_len | input | PIX_W (12) | Length of one pattern copy |
| rep_cnt | input | REP_W (4) | Number of pattern copies |
| tog_even | input | NUM_TOG*PIX_W (72) | Toggle offsets for even lines |
| tog_odd | input | NUM_TOG*PIX_W (72) | Toggle offsets for odd lines |
| hblk | output | 1 | Registered blanking gate |

## Verification
The bench targets these corner cases:
- **Toggle offsets at or past the pattern length.** A design that did not discard them would flip the gate in the tail.
- **A toggle at offset 0.** An off-by-one design would miss the inversion at the first position of every copy.
- **Two coincident toggles.** A design with a set-only toggle rule would leave the level inverted instead of cancelling.
- **A parity input that changes in mid-line.** A design that failed to hold the sampled parity would switch toggle sets partway through a line.
- **A zero repeat count and a zero length.** A design that mishandled them would leave holes in the window, or keep counting copies forever.
- **Non-repeat modes loaded with busy pattern settings.** Any leak of those settings would break the flat window.

// File: rtl/hblk_pkg.sv
`timescale 1ns/1ps
package hblk_pkg;
   localparam int          HB_MODE_W      = 2;
   localparam logic [1:0]  HB_MODE_REPEAT = 2'd1;
endpackage

// File: rtl/hblk_pix_count.sv
`timescale 1ns/1ps
// Pixel position counter with line parity capture.
module hblk_pix_count #(
   parameter int PIX_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             line_start,
   input  logic             line_odd,
   output logic [PIX_W-1:0] pix_q,
   output logic             odd_q
);
   localparam logic [PIX_W-1:0] PIX_MAX = {PIX_W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pix_q <= PIX_MAX;   // idle: parked past any window
         odd_q <= 1'b0;
      end else if (line_start) begin
         pix_q <= '0;
         odd_q <= line_odd;
      end else if (pix_q != PIX_MAX) begin
         pix_q <= pix_q + 1'b1;
      end
   end
endmodule

// File: rtl/hblk_rep_track.sv
`timescale 1ns/1ps
// Tracks offset within the current pattern copy and the copy index.
module hblk_rep_track #(
   parameter int PIX_W = 12,
   parameter int REP_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             line_start,
   input  logic             advance,
   input  logic [PIX_W-1:0] pat_len,
   input  logic [REP_W-1:0] rep_cnt,
   output logic [PIX_W-1:0] pos_q,
   output logic [REP_W-1:0] idx_q,
   output logic             pat_act
);
   logic [PIX_W:0] pos_inc;
   logic           wrap;

   assign pos_inc = {1'b0, pos_q} + 1'b1;
   assign wrap    = pos_inc >= {1'b0, pat_len};
   assign pat_act = (pat_len != '0) && (idx_q < rep_cnt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q <= '0;
         idx_q <= '0;
      end else if (line_start) begin
         pos_q <= '0;
         idx_q <= '0;
      end else if (advance && pat_act) begin
         if (wrap) begin
            pos_q <= '0;
            idx_q <= idx_q + 1'b1;
         end else begin
            pos_q <= pos_inc[PIX_W-1:0];
         end
      end
   end
endmodule

// File: rtl/hblk_tog_level.sv
`timescale 1ns/1ps
// Level inside a pattern copy: starts high, each valid toggle at or before pos inverts.
module hblk_tog_level #(
   parameter int PIX_W   = 12,
   parameter int NUM_TOG = 6
) (
   input  logic [PIX_W-1:0]         pos,
   input  logic [PIX_W-1:0]         pat_len,
   input  logic [NUM_TOG*PIX_W-1:0] togs,
   output logic                     level
);
   logic [NUM_TOG-1:0] hit;

   for (genvar i = 0; i < NUM_TOG; i++) begin : g_tog
      logic [PIX_W-1:0] t;
      assign t      = togs[i*PIX_W +: PIX_W];
      assign hit[i] = (t < pat_len) && (t <= pos);
   end

   assign level = ~(^hit);
endmodule

// File: rtl/hblk_repeat_gen.sv
`timescale 1ns/1ps
module hblk_repeat_gen #(
   parameter int PIX_W   = 12,
   parameter int REP_W   = 4,
   parameter int NUM_TOG = 6
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     line_start,
   input  logic                     line_odd,
   input  logic [1:0]               mode,
   input  logic [PIX_W-1:0]         win_start,
   input  logic [PIX_W-1:0]         win_end,
   input  logic [PIX_W-1:0]         pat_len,
   input  logic [REP_W-1:0]         rep_cnt,
   input  logic [NUM_TOG*PIX_W-1:0] tog_even,
   input  logic [NUM_TOG*PIX_W-1:0] tog_odd,
   output logic                     hblk
);
   import hblk_pkg::*;

   localparam int TOG_BUS_W = NUM_TOG * PIX_W;

   if (PIX_W < 2 || PIX_W > 24) begin : g_bad_pix
      $error("hblk_repeat_gen: PIX_W out of range");
   end
   if (REP_W < 1 || REP_W > 8) begin : g_bad_rep
      $error("hblk_repeat_gen: REP_W out of range");
   end
   if (NUM_TOG < 1 || NUM_TOG > 16) begin : g_bad_tog
      $error("hblk_repeat_gen: NUM_TOG out of range");
   end

   logic [PIX_W-1:0]     pix_q;
   logic                 odd_q;
   logic [PIX_W-1:0]     pos_q;
   logic [REP_W-1:0]     idx_q;
   logic                 pat_act;
   logic                 past_start;
   logic                 in_win;
   logic                 pat_level;
   logic                 hblk_d;
   logic                 hblk_q;
   logic [TOG_BUS_W-1:0] tog_sel;

   hblk_pix_count #(.PIX_W(PIX_W)) u_pix (
      .clk        (clk),
      .rst_n      (rst_n),
      .line_start (line_start),
      .line_odd   (line_odd),
      .pix_q      (pix_q),
      .odd_q      (odd_q)
   );

   assign past_start = pix_q >= win_start;
   assign in_win     = past_start && (pix_q < win_end);

   hblk_rep_track #(.PIX_W(PIX_W), .REP_W(REP_W)) u_rep (
      .clk        (clk),
      .rst_n      (rst_n),
      .line_start (line_start),
      .advance    (past_start),
      .pat_len    (pat_len),
      .rep_cnt    (rep_cnt),
      .pos_q      (pos_q),
      .idx_q      (idx_q),
      .pat_act    (pat_act)
   );

   assign tog_sel = odd_q ? tog_odd : tog_even;

   hblk_tog_level #(.PIX_W(PIX_W), .NUM_TOG(NUM_TOG)) u_lvl (
      .pos     (pos_q),
      .pat_len (pat_len),
      .togs    (tog_sel),
      .level   (pat_level)
   );

   always_comb begin
      hblk_d = 1'b0;
      if (in_win) begin
         if (mode == HB_MODE_REPEAT && pat_act) hblk_d = pat_level;
         else                                   hblk_d = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hblk_q <= 1'b0;
      else        hblk_q <= hblk_d;
   end

   assign hblk = hblk_q;
endmodule

// File: rtl/hblk_repeat_gen_chk.sv
`timescale 1ns/1ps
module hblk_repeat_gen_chk #(
   parameter int PIX_W = 12,
   parameter int REP_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             line_start,
   input logic [1:0]       mode,
   input logic [PIX_W-1:0] win_start,
   input logic [PIX_W-1:0] win_end,
   input logic [REP_W-1:0] rep_cnt,
   input logic             hblk,
   input logic [PIX_W-1:0] pix_q,
   input logic             odd_q,
   input logic [REP_W-1:0] idx_q
);
   p_line_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      line_start |=> (pix_q == '0));

   p_outside_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_q < win_start || pix_q >= win_end) |=> !hblk);

   p_plain_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != 2'd1 && pix_q >= win_start && pix_q < win_end) |=> hblk);

   p_parity_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !line_start |=> $stable(odd_q));

   p_tail_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd1 && idx_q >= rep_cnt && pix_q >= win_start && pix_q < win_end)
      |=> hblk);
endmodule

bind hblk_repeat_gen hblk_repeat_gen_chk #(.PIX_W(PIX_W), .REP_W(REP_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .line_start (line_start),
   .mode       (mode),
   .win_start  (win_start),
   .win_end    (win_end),
   .rep_cnt    (rep_cnt),
   .hblk       (hblk),
   .pix_q      (pix_q),
   .odd_q      (odd_q),
   .idx_q      (idx_q)
);

// File: tb/hblk_repeat_gen_bench.sv
`timescale 1ns/1ps
module hblk_repeat_gen_bench;
   localparam int PIX_W   = 12;
   localparam int REP_W   = 4;
   localparam int NUM_TOG = 6;
   localparam int LINE    = 60;
   localparam int IGN     = 4095;

   logic                     clk = 1'b0;
   logic                     rst_n = 1'b0;
   logic                     line_start = 1'b0;
   logic                     line_odd = 1'b0;
   logic [1:0]               mode = 2'd0;
   logic [PIX_W-1:0]         win_start = '0;
   logic [PIX_W-1:0]         win_end = '0;
   logic [PIX_W-1:0]         pat_len = '0;
   logic [REP_W-1:0]         rep_cnt = '0;
   logic [NUM_TOG*PIX_W-1:0] tog_even = '0;
   logic [NUM_TOG*PIX_W-1:0] tog_odd = '0;
   logic                     hblk;

   int tests = 0;
   int fails = 0;
   int tev[NUM_TOG];
   int tod[NUM_TOG];

   always #4 clk = ~clk;

   hblk_repeat_gen #(.PIX_W(PIX_W), .REP_W(REP_W), .NUM_TOG(NUM_TOG)) u_hblk_repeat_gen (
      .clk(clk), .rst_n(rst_n), .line_start(line_start), .line_odd(line_odd),
      .mode(mode), .win_start(win_start), .win_end(win_end), .pat_len(pat_len),
      .rep_cnt(rep_cnt), .tog_even(tog_even), .tog_odd(tog_odd), .hblk(hblk));

   task automatic load_cfg(input int md, input int s, input int e, input int l, input int r);
      mode = md[1:0]; win_start = s[PIX_W-1:0]; win_end = e[PIX_W-1:0];
      pat_len = l[PIX_W-1:0]; rep_cnt = r[REP_W-1:0];
      for (int i = 0; i < NUM_TOG; i++) begin
         tog_even[i*PIX_W +: PIX_W] = tev[i][PIX_W-1:0];
         tog_odd[i*PIX_W +: PIX_W]  = tod[i][PIX_W-1:0];
      end
   endtask

   function automatic bit ref_hblk(input int n, input bit odd);
      int s = int'(win_start);
      int e = int'(win_end);
      int l = int'(pat_len);
      int r = int'(rep_cnt);
      int off;
      int p;
      bit lvl;
      if (n < s || n >= e) return 1'b0;
      if (mode != 2'd1) return 1'b1;
      off = n - s;
      if (l == 0 || off >= l * r) return 1'b1;
      p = off % l;
      lvl = 1'b1;
      for (int i = 0; i < NUM_TOG; i++) begin
         int t = odd ? tod[i] : tev[i];
         if (t < l && t <= p) lvl = ~lvl;
      end
      return lvl;
   endfunction

   task automatic check(input string req, input bit act, input bit exp, input int n);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s pos %0d: hblk=%0b expected %0b", req, n, act, exp);
      end
   endtask

   task automatic run_line(input string req, input bit odd, input bit flip);
      @(negedge clk);
      line_start = 1'b1; line_odd = odd;
      @(negedge clk);
      line_start = 1'b0;
      if (flip) line_odd = ~odd;
      for (int n = 0; n < LINE; n++) begin
         @(negedge clk);
         check(req, hblk, ref_hblk(n, odd), n);
      end
   endtask

   // R1: idle after reset
   task automatic t_reset();
      for (int i = 0; i < NUM_TOG; i++) begin tev[i] = IGN; tod[i] = IGN; end
      load_cfg(0, 0, 4095, 5, 2);
      for (int n = 0; n < 10; n++) begin
         @(negedge clk);
         check("R1", hblk, 1'b0, n);
      end
   endtask

   // R2 R3 R4: plain window, pattern settings ignored
   task automatic t_plain();
      tev = '{0, 1, 2, 3, IGN, IGN};
      tod = '{1, 2, IGN, IGN, IGN, IGN};
      load_cfg(0, 4, 30, 5, 3);
      run_line("R4", 1'b0, 1'b0);
      load_cfg(2, 7, 25, 4, 2);
      run_line("R3", 1'b1, 1'b0);
   endtask

   // R5 R6: one copy, toggle beyond length ignored
   task automatic t_rep1_even();
      tev = '{2, 5, 9, IGN, IGN, IGN};
      tod = '{1, IGN, IGN, IGN, IGN, IGN};
      load_cfg(1, 6, 40, 8, 1);
      run_line("R6", 1'b0, 1'b0);
   endtask

   // R5 R7: three copies on an odd line
   task automatic t_rep3_odd();
      tev = '{3, IGN, IGN, IGN, IGN, IGN};
      tod = '{1, 3, 4, 6, IGN, IGN};
      load_cfg(1, 5, 45, 6, 3);
      run_line("R5", 1'b1, 1'b0);
      run_line("R5", 1'b0, 1'b0);
   endtask

   // R7: parity changes mid-line are ignored
   task automatic t_parity_hold();
      tev = '{2, 4, IGN, IGN, IGN, IGN};
      tod = '{0, 1, 3, IGN, IGN, IGN};
      load_cfg(1, 3, 50, 5, 3);
      run_line("R7", 1'b0, 1'b1);
      run_line("R7", 1'b1, 1'b1);
   endtask

   // R6 R9: toggle at 0, coincident toggles cancel
   task automatic t_coincide();
      tev = '{0, 2, 2, 5, 7, IGN};
      tod = tev;
      load_cfg(1, 2, 55, 7, 4);
      run_line("R9", 1'b0, 1'b0);
      run_line("R9", 1'b1, 1'b0);
   endtask

   // R8: zero repeat count, zero length, tail after copies
   task automatic t_tail();
      tev = '{1, 2, IGN, IGN, IGN, IGN};
      tod = '{1, IGN, IGN, IGN, IGN, IGN};
      load_cfg(1, 4, 40, 5, 0);
      run_line("R8", 1'b0, 1'b0);
      load_cfg(1, 4, 40, 0, 3);
      run_line("R8", 1'b1, 1'b0);
      load_cfg(1, 0, 59, 4, 2);
      run_line("R8", 1'b1, 1'b0);
   endtask

   initial begin
      #800000;
      fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_plain();
      t_rep1_even();
      t_rep3_odd();
      t_parity_hold();
      t_coincide();
      t_tail();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule